// File: doc/BRIEF.md
# Serially Programmed Nibble Control Register Bank

This block holds the configuration of a serial peripheral as a bank of 4-bit registers. The registers are loaded from characters that a UART receiver has already assembled. A character counts as a register write only while the data/control select input is low. Its low nibble is the value to store and its high nibble is the register address. A shadow-enable bit, kept in a dedicated control register, serves as a fifth address bit. With it the 4-bit address nibble reaches 31 registers in two windows of sixteen.

The same control register holds an echo-enable bit. When echo is on, every accepted character is handed back as an echo request, so the host can confirm the write. One register holds the baud-rate code. Writing it stages the new code. The code reaches the active baud output at once when echo is off. When echo is on, the code waits until the transmitter reports that the echo has left, so the echo still goes out at the old rate. A power-enable input freezes the bank while low, and a reset has no effect during that time. The UART itself lies outside this block.

Top module: `ctrlreg_file`

## Requirements
- R1: A clock edge with `rst` high and `pwr_on` high sets every register to 0, except register 14, the baud register, which is set to `BAUD_RST` (default 5). The same edge sets `baud_active` to `BAUD_RST` and clears `echo_req`.
- R2: A clock edge with `rx_valid` high, `dc_sel` low and `pwr_on` high is a write. With the shadow bit at 0, `rx_byte[3:0]` is stored in register `rx_byte[7:4]`, and `regs_flat[4*i +: 4]` shows register i from the next cycle.
- R3: A character presented while `dc_sel` is high changes no register.
- R4: With the shadow bit (register 15, bit 3) at 1, address nibbles 0 to 14 write registers 16 to 30. Registers 0 to 14 keep their values.
- R5: Address nibble 15 always writes register 15, whatever the shadow bit is. Address 31 is not a separate register.
- R6: If the echo-enable bit (register 15, bit 0) is 1 when a write arrives, `echo_req` is high for the following cycle with `echo_byte` equal to the character. If the bit is 0, `echo_req` stays low. The bit is taken as it was before the write.
- R7: With echo off, a write to register 14 moves its value to `baud_active` in the cycle after the write.
- R8: With echo on, a write to register 14 leaves `baud_active` unchanged until a cycle with `echo_done` high. The staged value appears on `baud_active` in the cycle after that one.
- R9: While `pwr_on` is low, neither writes nor `rst` change any register or `baud_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, effective only while `pwr_on` is high |
| pwr_on | input | 1 | High in normal operation; low freezes the bank |
| dc_sel | input | 1 | Low: received characters are register writes |
| rx_valid | input | 1 | One-cycle strobe, a character is present on `rx_byte` |
| rx_byte | input | 8 | Received character: [7:4] address, [3:0] data |
| echo_done | input | 1 | Strobe from the transmitter, echo has been sent |
| regs_flat | output | 124 | All 31 registers, register i at bits [4*i+3:4*i] |
| echo_req | output | 1 | One-cycle request to send `echo_byte` back |
| echo_byte | output | 8 | Character to echo |
| baud_active | output | 4 | Baud-rate code currently in force |

## Verification
The assertions take for granted that `rx_valid` is a strobe the receiver drives with a stable `rx_byte` in the same cycle. They also assume that `pwr_on` and `dc_sel` are defined from the first edge and that `echo_done` arrives only as a single-cycle pulse. The stimulus changes inputs only on falling edges, holds every strobe for exactly one cycle, and starts with `pwr_on` high and reset asserted. It raises `echo_done` only after an echo request has been seen. The echo-gated baud check also assumes that the register holding the echo bit is not rewritten in the same cycle as a baud write.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  parameter int unsigned NIB_W = 4;
  localparam int unsigned IDX_W = NIB_W + 1;
  localparam int unsigned NREG  = (1 << IDX_W) - 1;
  localparam int unsigned SH_IDX = (1 << NIB_W) - 1;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [NIB_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
  import ctrlreg_pkg::*;
(
  input  logic               shadow_en,
  input  logic               rx_valid,
  input  logic               dc_sel,
  input  logic               pwr_on,
  input  logic [2*NIB_W-1:0] rx_byte,
  output wr_req_t            req
);
  logic [NIB_W-1:0] addr_nib;

  always_comb begin
    addr_nib = rx_byte[2*NIB_W-1:NIB_W];
    req.hit  = rx_valid && !dc_sel && pwr_on;
    req.data = rx_byte[NIB_W-1:0];
    // the control register is visible from both windows
    if (addr_nib == '1) req.idx = {1'b0, addr_nib};
    else                req.idx = {shadow_en, addr_nib};
  end
endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
  import ctrlreg_pkg::*;
#(
  parameter int unsigned BAUD_IDX = 14,
  parameter logic [NIB_W-1:0] BAUD_RST = 4'd5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_on,
  input  wr_req_t               req,
  output logic [NREG*NIB_W-1:0] regs_flat
);
  logic [NIB_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst && pwr_on) begin
      for (int i = 0; i < int'(NREG); i++)
        mem[i] <= (i == int'(BAUD_IDX)) ? BAUD_RST : '0;
    end else if (req.hit) begin
      mem[req.idx] <= req.data;
    end
  end

  for (genvar g = 0; g < int'(NREG); g++) begin : g_flat
    assign regs_flat[g*NIB_W +: NIB_W] = mem[g];
  end
endmodule

// File: rtl/ctrlreg_baud.sv
module ctrlreg_baud
  import ctrlreg_pkg::*;
#(
  parameter int unsigned BAUD_IDX = 14,
  parameter logic [NIB_W-1:0] BAUD_RST = 4'd5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_on,
  input  wr_req_t          req,
  input  logic             echo_on,
  input  logic             echo_done,
  input  logic [NIB_W-1:0] staged,
  output logic [NIB_W-1:0] baud_active
);
  logic pending;
  logic baud_wr;

  assign baud_wr = req.hit && (req.idx == IDX_W'(BAUD_IDX));

  always_ff @(posedge clk) begin
    if (rst && pwr_on) begin
      baud_active <= BAUD_RST;
      pending     <= 1'b0;
    end else if (pwr_on) begin
      if (baud_wr) begin
        if (echo_on) begin
          pending <= 1'b1;
        end else begin
          baud_active <= req.data;
          pending     <= 1'b0;
        end
      end else if (pending && echo_done) begin
        baud_active <= staged;
        pending     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctrlreg_file.sv
module ctrlreg_file
  import ctrlreg_pkg::*;
#(
  parameter int unsigned SHADOW_BIT = 3,
  parameter int unsigned ECHO_BIT   = 0,
  parameter int unsigned BAUD_IDX   = 14,
  parameter logic [NIB_W-1:0] BAUD_RST = 4'd5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_on,
  input  logic                  dc_sel,
  input  logic                  rx_valid,
  input  logic [2*NIB_W-1:0]    rx_byte,
  input  logic                  echo_done,
  output logic [NREG*NIB_W-1:0] regs_flat,
  output logic                  echo_req,
  output logic [2*NIB_W-1:0]    echo_byte,
  output logic [NIB_W-1:0]      baud_active
);
  wr_req_t          req;
  logic [NIB_W-1:0] ctl_nib;
  logic             shadow_en;
  logic             echo_on;

  assign ctl_nib   = regs_flat[SH_IDX*NIB_W +: NIB_W];
  assign shadow_en = ctl_nib[SHADOW_BIT];
  assign echo_on   = ctl_nib[ECHO_BIT];

  ctrlreg_decode u_dec (
    .shadow_en (shadow_en),
    .rx_valid  (rx_valid),
    .dc_sel    (dc_sel),
    .pwr_on    (pwr_on),
    .rx_byte   (rx_byte),
    .req       (req)
  );

  ctrlreg_bank #(.BAUD_IDX(BAUD_IDX), .BAUD_RST(BAUD_RST)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .pwr_on    (pwr_on),
    .req       (req),
    .regs_flat (regs_flat)
  );

  ctrlreg_baud #(.BAUD_IDX(BAUD_IDX), .BAUD_RST(BAUD_RST)) u_baud (
    .clk         (clk),
    .rst         (rst),
    .pwr_on      (pwr_on),
    .req         (req),
    .echo_on     (echo_on),
    .echo_done   (echo_done),
    .staged      (regs_flat[BAUD_IDX*NIB_W +: NIB_W]),
    .baud_active (baud_active)
  );

  always_ff @(posedge clk) begin
    if (rst && pwr_on) begin
      echo_req  <= 1'b0;
      echo_byte <= '0;
    end else begin
      echo_req <= req.hit && echo_on;
      if (req.hit) echo_byte <= rx_byte;
    end
  end
endmodule

// File: rtl/ctrlreg_chk.sv
module ctrlreg_chk
  import ctrlreg_pkg::*;
#(
  parameter logic [NIB_W-1:0] BAUD_RST = 4'd5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pwr_on,
  input logic                  dc_sel,
  input logic                  rx_valid,
  input logic [2*NIB_W-1:0]    rx_byte,
  input logic                  echo_done,
  input logic [NREG*NIB_W-1:0] regs_flat,
  input logic                  echo_req,
  input logic [NIB_W-1:0]      baud_active
);
  logic settled = 1'b0;
  logic wr_now;

  assign wr_now = rx_valid && !dc_sel && pwr_on;

  always_ff @(posedge clk) settled <= !rst;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (rst && pwr_on) |=> (baud_active == BAUD_RST) && !echo_req);

  // R3
  ctl_ignored_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (rx_valid && dc_sel) |=> $stable(regs_flat));

  // R5
  ctl_reach_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (wr_now && rx_byte[2*NIB_W-1:NIB_W] == '1)
      |=> regs_flat[SH_IDX*NIB_W +: NIB_W] == $past(rx_byte[NIB_W-1:0]));

  // R6
  echo_cause_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    echo_req |-> $past(wr_now));

  // R8
  baud_cause_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    !$stable(baud_active) |-> ($past(echo_done) || $past(wr_now)));

  // R9
  frozen_chk: assert property (@(posedge clk)
    !pwr_on |=> $stable(regs_flat) && $stable(baud_active));
endmodule

bind ctrlreg_file ctrlreg_chk #(.BAUD_RST(BAUD_RST)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_on      (pwr_on),
  .dc_sel      (dc_sel),
  .rx_valid    (rx_valid),
  .rx_byte     (rx_byte),
  .echo_done   (echo_done),
  .regs_flat   (regs_flat),
  .echo_req    (echo_req),
  .baud_active (baud_active)
);

// File: tb/tb_ctrlreg_file.sv
module tb_ctrlreg_file;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pwr_on = 1'b1;
  logic         dc_sel = 1'b1;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         echo_done = 1'b0;
  logic [123:0] regs_flat;
  logic         echo_req;
  logic [7:0]   echo_byte;
  logic [3:0]   baud_active;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [3:0] mdl [31];
  logic [3:0] exp_baud;
  logic       exp_echo;

  always #4 clk = ~clk;

  ctrlreg_file dut (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .dc_sel(dc_sel),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .echo_done(echo_done),
    .regs_flat(regs_flat), .echo_req(echo_req), .echo_byte(echo_byte),
    .baud_active(baud_active)
  );

  function automatic logic [123:0] mdl_flat();
    logic [123:0] v;
    for (int i = 0; i < 31; i++) v[i*4 +: 4] = mdl[i];
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one character on a falling edge; result visible at the next falling edge
  task automatic send(logic [7:0] ch, logic dc);
    logic [4:0] idx;
    exp_echo = 1'b0;
    if (!dc && pwr_on) begin
      exp_echo = mdl[15][0];
      idx = (ch[7:4] == 4'hF) ? 5'd15 : {mdl[15][3], ch[7:4]};
      mdl[idx] = ch[3:0];
    end
    rx_byte = ch; dc_sel = dc; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; dc_sel = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 31; i++) mdl[i] = 4'h0;
    mdl[14] = 4'd5;
    exp_baud = 4'd5;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 regs", 128'(regs_flat), 128'(mdl_flat()));
    chk("R1 baud", 128'(baud_active), 128'(4'd5));
    chk("R1 echo_req", 128'(echo_req), 128'(1'b0));
  endtask

  task automatic t_low_window();
    send(8'h3A, 1'b0);
    chk("R2 addr3", 128'(regs_flat[12 +: 4]), 128'(4'hA));
    send(8'h05, 1'b0);
    send(8'hC6, 1'b0);
    chk("R2 pattern", 128'(regs_flat), 128'(mdl_flat()));
  endtask

  task automatic t_dc_high();
    send(8'h3F, 1'b1);
    send(8'h71, 1'b1);
    chk("R3 ignored", 128'(regs_flat), 128'(mdl_flat()));
    chk("R3 addr3 kept", 128'(regs_flat[12 +: 4]), 128'(4'hA));
  endtask

  task automatic t_shadow();
    send(8'hF8, 1'b0);
    chk("R5 ctl set", 128'(regs_flat[60 +: 4]), 128'(4'h8));
    send(8'h39, 1'b0);
    send(8'hE2, 1'b0);
    chk("R4 reg19", 128'(regs_flat[76 +: 4]), 128'(4'h9));
    chk("R4 reg30", 128'(regs_flat[120 +: 4]), 128'(4'h2));
    chk("R4 low kept", 128'(regs_flat[12 +: 4]), 128'(4'hA));
    chk("R4 baud kept", 128'(baud_active), 128'(exp_baud));
    send(8'hF0, 1'b0);
    chk("R5 ctl via high window", 128'(regs_flat[60 +: 4]), 128'(4'h0));
    chk("R5 whole bank", 128'(regs_flat), 128'(mdl_flat()));
  endtask

  task automatic t_echo();
    send(8'hF1, 1'b0);
    chk("R6 no echo when off", 128'(echo_req), 128'(1'b0));
    send(8'h26, 1'b0);
    chk("R6 echo_req", 128'(echo_req), 128'(exp_echo));
    chk("R6 echo_byte", 128'(echo_byte), 128'(8'h26));
    @(negedge clk);
    chk("R6 one cycle", 128'(echo_req), 128'(1'b0));
    send(8'hF0, 1'b0);
    chk("R6 echo of disabling write", 128'(echo_req), 128'(1'b1));
    send(8'h47, 1'b0);
    chk("R6 echo off", 128'(echo_req), 128'(1'b0));
  endtask

  task automatic t_baud_now();
    send(8'hE7, 1'b0);
    exp_baud = 4'd7;
    chk("R7 immediate", 128'(baud_active), 128'(exp_baud));
  endtask

  task automatic t_baud_echo();
    send(8'hF1, 1'b0);
    send(8'hE3, 1'b0);
    chk("R8 echo seen", 128'(echo_req), 128'(1'b1));
    chk("R8 held", 128'(baud_active), 128'(exp_baud));
    repeat (3) @(negedge clk);
    chk("R8 still held", 128'(baud_active), 128'(exp_baud));
    echo_done = 1'b1;
    @(negedge clk);
    echo_done = 1'b0;
    exp_baud = 4'd3;
    chk("R8 after echo_done", 128'(baud_active), 128'(exp_baud));
    send(8'hF0, 1'b0);
  endtask

  task automatic t_frozen();
    pwr_on = 1'b0;
    send(8'h2D, 1'b0);
    send(8'hE1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 regs frozen", 128'(regs_flat), 128'(mdl_flat()));
    chk("R9 baud frozen", 128'(baud_active), 128'(exp_baud));
    pwr_on = 1'b1;
    @(negedge clk);
    chk("R9 resume kept", 128'(regs_flat), 128'(mdl_flat()));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_low_window();
    t_dc_high();
    t_shadow();
    t_echo();
    t_baud_now();
    t_baud_echo();
    t_frozen();
    t_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule